// File: doc/BRIEF.md
# Single-to-Half Precision Converter

This block turns a 32-bit IEEE-754 single-precision word into a 16-bit half-precision word. Every request carries its own 2-bit rounding selector, so a stream of conversions can mix rounding toward negative infinity, rounding toward positive infinity and round-to-nearest-even from one cycle to the next.

The block handles every input class. Infinities and NaNs map to their half-precision forms. Magnitudes too large for the format overflow. Magnitudes too small for a normal half become denormals or zero. A rounding increment may carry out of the mantissa into the exponent. The result is registered, and its valid flag follows the request valid with one cycle of latency. No flags are produced, and NaN payloads are not kept.

Top module: `sp2hp_convert`

## Requirements
- R1: An input exponent field of 255 gives signed infinity (magnitude 0x7C00) when the input mantissa is zero. Any nonzero mantissa gives a signed quiet NaN (magnitude 0x7E00).
- R2: When the rebiased exponent (input exponent minus 112) is 31 or more, nearest mode (mode 2) gives signed infinity.
- R3: On overflow in a directed mode, the result is signed infinity when the mode rounds away from zero for that sign. Mode 0 rounds away from zero for negative inputs and mode 1 for positive inputs. In the other directed case the result is signed max-finite (magnitude 0x7BFF).
- R4: When the rebiased exponent is below -10, the result is signed zero. The exception is a nonzero input magnitude in a directed mode that rounds away from zero for that sign; the result is then the smallest denormal (magnitude 0x0001).
- R5: When the rebiased exponent lies between -10 and 0, the output exponent field is 0. The mantissa, with its implicit leading one restored, is shifted right by 14 minus the rebiased exponent.
- R6: When the rebiased exponent lies between 1 and 30, it is placed in output bits 14:10. The output mantissa is the top 10 input mantissa bits.
- R7: In nearest mode, the result is incremented when the discarded bits exceed half a unit in the last place. On an exact tie, it is incremented only when the kept LSB is 1.
- R8: In a directed mode, the result is incremented when any discarded bit is nonzero and the mode rounds away from zero for the sign. Otherwise the result is truncated.
- R9: A rounding increment carries into the exponent. A denormal can become the smallest normal, and the largest finite value can become infinity.
- R10: Mode value 3 behaves exactly as nearest mode.
- R11: outValid is inValid delayed by one cycle. outHalf changes only on the cycle after an accepted request and holds otherwise.
- R12: During reset, outValid and outHalf are 0.
- R13: The output sign bit 15 always equals input bit 31, including for zero and NaN inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| inWord | input | 32 | Single-precision operand |
| inMode | input | 2 | Rounding: 0 toward -inf, 1 toward +inf, 2 or 3 nearest-even |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| outHalf | output | 16 | Registered half-precision result |

## Verification
The hardest cases to reach are rounding increments that ripple across a field boundary. They occur at three points: the largest denormal rounding to the smallest normal, an all-ones mantissa rolling into the next binade, and the top of the finite range rounding to infinity. The stimulus hand-builds operands with exactly the needed mantissa bits. Exact ties are placed in both even and odd kept LSB positions, including a tie where every kept bit is gone (rebiased exponent -10). The sign is paired with each directed mode, so both the away-from-zero and toward-zero paths are taken at overflow and at deep underflow.

// File: rtl/sp2hp_pkg.sv
package sp2hp_pkg;
  localparam int SP_W      = 32;
  localparam int SP_EXP_W  = 8;
  localparam int SP_MAN_W  = 23;
  localparam int HP_W      = 16;
  localparam int HP_EXP_W  = 5;
  localparam int HP_MAN_W  = 10;
  localparam int MODE_W    = 2;
  localparam int SP_BIAS   = 127;
  localparam int HP_BIAS   = 15;
  localparam int REBIAS    = SP_BIAS - HP_BIAS;
  localparam int MAN_DROP  = SP_MAN_W - HP_MAN_W;
  localparam int HP_MAG_W  = HP_W - 1;
  localparam int FULL_W    = SP_MAN_W + 1;
  localparam int REB_W     = SP_EXP_W + 2;
  localparam int SH_W      = 5;

  localparam logic [MODE_W-1:0] MODE_DOWN = 2'd0;
  localparam logic [MODE_W-1:0] MODE_UP   = 2'd1;

  localparam logic [HP_MAG_W-1:0] MAG_INF  = 15'h7C00;
  localparam logic [HP_MAG_W-1:0] MAG_QNAN = 15'h7E00;
  localparam logic [HP_MAG_W-1:0] MAG_MAX  = 15'h7BFF;
  localparam logic [HP_MAG_W-1:0] MAG_TINY = 15'h0001;

  typedef struct packed {
    logic load;
    logic validNext;
  } sp2hp_strobe_t;
endpackage

// File: rtl/sp2hp_ctrl.sv
module sp2hp_ctrl
  import sp2hp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inValid,
  output sp2hp_strobe_t stb,
  output logic          outValid
);
  always_comb begin
    stb.load      = inValid;
    stb.validNext = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= stb.validNext;
  end
endmodule

// File: rtl/sp2hp_datapath.sv
module sp2hp_datapath
  import sp2hp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  sp2hp_strobe_t     stb,
  input  logic [SP_W-1:0]   inWord,
  input  logic [MODE_W-1:0] inMode,
  output logic [HP_W-1:0]   outHalf
);
  logic                       sgn;
  logic [SP_EXP_W-1:0]        expIn;
  logic [SP_MAN_W-1:0]        manIn;
  logic signed [REB_W-1:0]    reb;
  logic                       isSpecial, isOver, isUnder, isSub;
  logic                       nearest, awayZero;
  logic [FULL_W-1:0]          fullMan;
  logic [SH_W-1:0]            shAmt;
  logic [HP_EXP_W-1:0]        hpExp;
  logic [HP_MAN_W-1:0]        kept;
  logic [FULL_W:0]            remMask, remBits, halfUlp;
  logic                       bumpUp;
  logic [HP_MAG_W-1:0]        roundedMag, magSel;
  logic [HP_W-1:0]            result;

  always_comb begin
    sgn      = inWord[SP_W-1];
    expIn    = inWord[SP_W-2 -: SP_EXP_W];
    manIn    = inWord[SP_MAN_W-1:0];
    reb      = $signed({2'b00, expIn}) - REB_W'(REBIAS);
    nearest  = inMode[1];
    awayZero = (inMode == MODE_DOWN && sgn) || (inMode == MODE_UP && !sgn);

    isSpecial = (expIn == '1);
    isOver    = (reb >= REB_W'(31));
    isUnder   = (reb < -REB_W'(HP_MAN_W));
    isSub     = (reb <= 0);

    if (isSub) begin
      fullMan = {1'b1, manIn};
      shAmt   = SH_W'(REB_W'(MAN_DROP + 1) - reb);
      hpExp   = '0;
    end else begin
      fullMan = {1'b0, manIn};
      shAmt   = SH_W'(MAN_DROP);
      hpExp   = reb[HP_EXP_W-1:0];
    end

    kept    = HP_MAN_W'(fullMan >> shAmt);
    remMask = ((FULL_W+1)'(1) << shAmt) - (FULL_W+1)'(1);
    remBits = {1'b0, fullMan} & remMask;
    halfUlp = (FULL_W+1)'(1) << (shAmt - SH_W'(1));

    if (nearest)
      bumpUp = (remBits > halfUlp) || (remBits == halfUlp && kept[0]);
    else
      bumpUp = awayZero && (remBits != '0);

    roundedMag = {hpExp, kept} + HP_MAG_W'(bumpUp);

    if (isSpecial)
      magSel = (manIn == '0) ? MAG_INF : MAG_QNAN;
    else if (isOver)
      magSel = (nearest || awayZero) ? MAG_INF : MAG_MAX;
    else if (isUnder)
      magSel = (awayZero && (expIn != '0 || manIn != '0)) ? MAG_TINY : '0;
    else
      magSel = roundedMag;

    result = {sgn, magSel};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        outHalf <= '0;
    else if (stb.load) outHalf <= result;
  end
endmodule

// File: rtl/sp2hp_convert.sv
module sp2hp_convert
  import sp2hp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [SP_W-1:0]   inWord,
  input  logic [MODE_W-1:0] inMode,
  output logic              outValid,
  output logic [HP_W-1:0]   outHalf
);
  sp2hp_strobe_t stb;

  sp2hp_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  sp2hp_datapath u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .inWord  (inWord),
    .inMode  (inMode),
    .outHalf (outHalf)
  );
endmodule

// File: rtl/sp2hp_convert_chk.sv
module sp2hp_convert_chk
  import sp2hp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic [SP_W-1:0]   inWord,
  input logic [MODE_W-1:0] inMode,
  input logic              outValid,
  input logic [HP_W-1:0]   outHalf
);
  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  // R11
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  // R11
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !inValid) |=> $stable(outHalf));

  // R13
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outHalf[HP_W-1] == $past(inWord[SP_W-1]));

  // R1
  nan_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inWord[30:23] == 8'hFF && inWord[22:0] != '0)
      |=> outHalf[HP_W-2:0] == MAG_QNAN);

  // R2
  ovf_near_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inMode[1] && inWord[30:23] >= 8'd143 && inWord[30:23] != 8'hFF)
      |=> outHalf[HP_W-2:0] == MAG_INF);
endmodule

bind sp2hp_convert sp2hp_convert_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .inWord   (inWord),
  .inMode   (inMode),
  .outValid (outValid),
  .outHalf  (outHalf)
);

// File: tb/sp2hp_convert_tb.sv
module sp2hp_convert_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic [1:0]  inMode = '0;
  logic        outValid;
  logic [15:0] outHalf;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sp2hp_convert u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inWord(inWord),
    .inMode(inMode), .outValid(outValid), .outHalf(outHalf)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic conv(input logic [31:0] w, input logic [1:0] m, input logic [15:0] exp, input string req);
    logic [15:0] held;
    @(negedge clk);
    inWord = w; inMode = m; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; inWord = 32'h7FC0_0000; inMode = 2'd1;
    chk(outValid === 1'b1, {req, " (R11 valid)"}, 32'(outValid), 32'd1);
    chk(outHalf === exp, req, 32'(outHalf), 32'(exp));
    held = outHalf;
    @(negedge clk);
    chk(outValid === 1'b0 && outHalf === held, {req, " (R11 hold)"}, {15'd0, outValid, outHalf}, {16'd0, held});
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(outValid === 1'b0, "R12 valid", 32'(outValid), 0);
    chk(outHalf === 16'h0, "R12 data", 32'(outHalf), 0);
    rst_n = 1'b1;
  endtask

  task automatic test_specials();
    conv(32'h7F80_0000, 2'd2, 16'h7C00, "R1 +inf");
    conv(32'hFF80_0000, 2'd0, 16'hFC00, "R1 -inf");
    conv(32'h7FC0_0001, 2'd1, 16'h7E00, "R1 qnan");
    conv(32'hFF80_0001, 2'd2, 16'hFE00, "R1 -nan R13");
  endtask

  task automatic test_overflow();
    conv(32'h4780_0000, 2'd2, 16'h7C00, "R2 +ovf nearest");
    conv(32'hC780_0000, 2'd2, 16'hFC00, "R2 -ovf nearest");
    conv(32'h4780_0000, 2'd1, 16'h7C00, "R3 +ovf up");
    conv(32'h4780_0000, 2'd0, 16'h7BFF, "R3 +ovf down");
    conv(32'hC780_0000, 2'd0, 16'hFC00, "R3 -ovf down");
    conv(32'hC780_0000, 2'd1, 16'hFBFF, "R3 -ovf up");
  endtask

  task automatic test_underflow();
    conv(32'h3280_0000, 2'd2, 16'h0000, "R4 tiny nearest");
    conv(32'h3280_0000, 2'd1, 16'h0001, "R4 tiny up");
    conv(32'h3280_0000, 2'd0, 16'h0000, "R4 tiny down");
    conv(32'hB280_0000, 2'd0, 16'h8001, "R4 -tiny down");
    conv(32'hB280_0000, 2'd1, 16'h8000, "R4 -tiny up");
    conv(32'h0000_0000, 2'd1, 16'h0000, "R4 zero up");
    conv(32'h8000_0000, 2'd0, 16'h8000, "R13 -zero down");
  endtask

  task automatic test_denormal();
    conv(32'h3380_0000, 2'd2, 16'h0001, "R5 2^-24");
    conv(32'h3800_0000, 2'd2, 16'h0200, "R5 2^-15");
    conv(32'h3300_0000, 2'd2, 16'h0000, "R5 R7 2^-25 tie even");
    conv(32'h3300_0000, 2'd1, 16'h0001, "R5 R8 2^-25 up");
    conv(32'h3340_0000, 2'd2, 16'h0001, "R5 R7 1.5*2^-25");
  endtask

  task automatic test_normal_round();
    conv(32'h3F80_0000, 2'd0, 16'h3C00, "R6 one");
    conv(32'hC000_0000, 2'd2, 16'hC000, "R6 minus two");
    conv(32'h3F80_1000, 2'd2, 16'h3C00, "R7 tie even keep");
    conv(32'h3F80_3000, 2'd2, 16'h3C02, "R7 tie odd bump");
    conv(32'h3F80_1001, 2'd2, 16'h3C01, "R7 above half");
    conv(32'h3F80_0001, 2'd1, 16'h3C01, "R8 +up");
    conv(32'h3F80_0001, 2'd0, 16'h3C00, "R8 +down");
    conv(32'hBF80_0001, 2'd0, 16'hBC01, "R8 -down");
    conv(32'hBF80_0001, 2'd1, 16'hBC00, "R8 -up");
  endtask

  task automatic test_carry();
    conv(32'h387F_FFFF, 2'd2, 16'h0400, "R9 denorm to normal");
    conv(32'h3FFF_F000, 2'd2, 16'h4000, "R9 binade carry");
    conv(32'h477F_EFFF, 2'd2, 16'h7BFF, "R9 below max tie");
    conv(32'h477F_F000, 2'd2, 16'h7C00, "R9 max to inf");
    conv(32'h477F_E001, 2'd1, 16'h7C00, "R9 up to inf");
  endtask

  task automatic test_mode3();
    conv(32'h3F80_3000, 2'd3, 16'h3C02, "R10 tie odd");
    conv(32'h4780_0000, 2'd3, 16'h7C00, "R10 overflow");
    conv(32'hB280_0000, 2'd3, 16'h8000, "R10 underflow");
  endtask

  task automatic test_back2back();
    @(negedge clk);
    inWord = 32'h3F80_0000; inMode = 2'd2; inValid = 1'b1;
    @(negedge clk);
    inWord = 32'hC000_0000;
    chk(outValid === 1'b1 && outHalf === 16'h3C00, "R11 b2b first", {15'd0, outValid, outHalf}, 32'h1_3C00);
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid === 1'b1 && outHalf === 16'hC000, "R11 b2b second", {15'd0, outValid, outHalf}, 32'h1_C000);
    @(negedge clk);
    chk(outValid === 1'b0, "R11 b2b drop", 32'(outValid), 0);
  endtask

  initial begin
    test_reset();
    test_specials();
    test_overflow();
    test_underflow();
    test_denormal();
    test_normal_round();
    test_carry();
    test_mode3();
    test_back2back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule